// File: doc/BRIEF.md
# Watchdog Reload Counter with Byte Register Access

This block is the counting core of a watchdog timer. A 24-bit down-counter decrements on each clock-enable tick. When it reaches zero, the block emits a one-cycle timeout pulse and then waits at zero. The starting value comes from a reload value that software writes one byte at a time over a small byte-wide register bus. The bus has an address, a write strobe, a read strobe and data lines.

A refresh strobe copies the stored reload value into the counter. This strobe stands for the processor executing its watchdog-service instruction. The three reload addresses behave asymmetrically. A write changes the stored reload byte. A read from the same address returns the matching byte of the running count.

A reload value below 4 is unsafe. If one is present at refresh, the counter loads 4 instead and a sticky error flag is raised. After reset the counter already holds the default reload value, so it counts without any refresh.

Top module: `wdt_reload_counter`

## Requirements
- R1: After reset the counter holds 0x000400, `timeout` and `min_err` are 0, and `reg_rdata` is 0x00.
- R2: A write to address 0xFF1 replaces reload bits 23:16, to 0xFF2 replaces bits 15:8, and to 0xFF3 replaces bits 7:0. The other bytes are unchanged, and the new value reaches the counter at the next refresh.
- R3: A reload write without a refresh leaves the counter unchanged.
- R4: A read strobe to 0xFF1, 0xFF2 or 0xFF3 returns count bits 23:16, 15:8 or 7:0 on `reg_rdata` in the following cycle. A read to any other address, or a cycle with no read strobe, gives 0x00 there.
- R5: Each cycle with `tick_en` high and no refresh lowers a nonzero count by exactly one. With `tick_en` low the count holds.
- R6: `timeout` is high for exactly the one cycle in which the count has just stepped from 1 to 0. The count then stays at zero until a refresh.
- R7: A refresh with a stored reload below 0x000004 loads 0x000004 and sets `min_err`. `min_err` stays set until reset, and any count loaded by a refresh is at least 4.
- R8: A refresh in the same cycle as a reload byte write loads the reload value from before that write.
- R9: A refresh takes priority over a tick in the same cycle: the count equals the reload value, not the reload value less one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-enable tick |
| refresh | input | 1 | Watchdog service strobe: load reload value into counter |
| reg_addr | input | 12 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| timeout | output | 1 | One-cycle pulse when the count reaches zero |
| min_err | output | 1 | Sticky flag: a reload below 4 was applied |

## Verification
The counter is loaded with several reload patterns whose three bytes all differ, such as 0x123456 and 0x000410. Reading back all three addresses after each load shows that each byte lane lands where it should and is not swapped. Short tick bursts, and idle gaps with no tick, separate a correct decrement from a stalled or double-stepping counter. A small reload of 6 exposes the exact timeout cycle and the hold at zero. Reloads of 2 and 0 exercise the clamp to 4. Two single-cycle collisions are also driven: a write together with a refresh, and a tick together with a refresh. They show which value wins in each case.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int WDT_CNT_W  = 24;
    localparam int WDT_BYTE_W = 8;
    localparam int WDT_ADDR_W = 12;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_CLAMP,
        ACT_DEC
    } cnt_act_e;
endpackage

// File: rtl/wdt_reload_regs.sv
module wdt_reload_regs #(
    parameter int ADDR_W    = wdt_pkg::WDT_ADDR_W,
    parameter int BYTE_W    = wdt_pkg::WDT_BYTE_W,
    parameter int NUM_BYTES = 3,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'hFF1,
    parameter logic [NUM_BYTES*BYTE_W-1:0] RESET_RELOAD = 'h400
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [NUM_BYTES*BYTE_W-1:0] reload_o
);
    localparam int VAL_W = NUM_BYTES * BYTE_W;

    logic [VAL_W-1:0]     reload_d, reload_q;
    logic [NUM_BYTES-1:0] hit;

    // Offset 0 addresses the most significant byte lane.
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_hit
        localparam logic [ADDR_W-1:0] LANE_ADDR = BASE_ADDR + ADDR_W'(k);
        assign hit[k] = wr_en && (addr == LANE_ADDR);
    end

    always_comb begin
        reload_d = reload_q;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (hit[k]) begin
                reload_d[(NUM_BYTES-1-k)*BYTE_W +: BYTE_W] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reload_q <= RESET_RELOAD;
        else        reload_q <= reload_d;
    end

    assign reload_o = reload_q;
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = wdt_pkg::WDT_CNT_W,
    parameter logic [CNT_W-1:0] MIN_RELOAD   = 'd4,
    parameter logic [CNT_W-1:0] RESET_RELOAD = 'h400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o,
    output logic             min_err_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             timeout;
        logic             min_err;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    cnt_act_e   act;

    always_comb begin
        if (refresh) begin
            act = (reload_i < MIN_RELOAD) ? ACT_CLAMP : ACT_LOAD;
        end else if (tick_en && (s_q.count != '0)) begin
            act = ACT_DEC;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        s_d         = s_q;
        s_d.timeout = 1'b0;
        unique case (act)
            ACT_LOAD:  s_d.count = reload_i;
            ACT_CLAMP: begin
                s_d.count   = MIN_RELOAD;
                s_d.min_err = 1'b1;
            end
            ACT_DEC: begin
                s_d.count   = s_q.count - CNT_W'(1);
                s_d.timeout = (s_q.count == CNT_W'(1));
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{count: RESET_RELOAD, timeout: 1'b0, min_err: 1'b0};
        else        s_q <= s_d;
    end

    assign count_o   = s_q.count;
    assign timeout_o = s_q.timeout;
    assign min_err_o = s_q.min_err;
endmodule

// File: rtl/wdt_read_port.sv
module wdt_read_port #(
    parameter int ADDR_W    = wdt_pkg::WDT_ADDR_W,
    parameter int BYTE_W    = wdt_pkg::WDT_BYTE_W,
    parameter int NUM_BYTES = 3,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'hFF1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BYTES*BYTE_W-1:0] count_i,
    output logic [BYTE_W-1:0]           rdata_o
);
    logic [BYTE_W-1:0]    rdata_d, rdata_q;
    logic [NUM_BYTES-1:0] sel;

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_sel
        localparam logic [ADDR_W-1:0] LANE_ADDR = BASE_ADDR + ADDR_W'(k);
        assign sel[k] = rd_en && (addr == LANE_ADDR);
    end

    always_comb begin
        rdata_d = '0;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (sel[k]) rdata_d = count_i[(NUM_BYTES-1-k)*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/wdt_reload_counter.sv
module wdt_reload_counter #(
    parameter int ADDR_W    = wdt_pkg::WDT_ADDR_W,
    parameter int BYTE_W    = wdt_pkg::WDT_BYTE_W,
    parameter int CNT_W     = wdt_pkg::WDT_CNT_W,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = 'hFF1,
    parameter logic [CNT_W-1:0]  MIN_RELOAD   = 'd4,
    parameter logic [CNT_W-1:0]  RESET_RELOAD = 'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              refresh,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              timeout,
    output logic              min_err
);
    localparam int NUM_BYTES = CNT_W / BYTE_W;

    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] count_w;

    wdt_reload_regs #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES),
        .BASE_ADDR(BASE_ADDR), .RESET_RELOAD(RESET_RELOAD)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .reload_o(reload_w)
    );

    wdt_down_counter #(
        .CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD), .RESET_RELOAD(RESET_RELOAD)
    ) cnt_i (
        .clk(clk), .rst_n(rst_n), .refresh(refresh), .tick_en(tick_en),
        .reload_i(reload_w), .count_o(count_w), .timeout_o(timeout),
        .min_err_o(min_err)
    );

    wdt_read_port #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES),
        .BASE_ADDR(BASE_ADDR)
    ) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .addr(reg_addr),
        .count_i(count_w), .rdata_o(reg_rdata)
    );
endmodule

// File: rtl/wdt_reload_counter_chk.sv
module wdt_reload_counter_chk #(
    parameter int ADDR_W = 12,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 24,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 'hFF1,
    parameter logic [CNT_W-1:0]  MIN_RELOAD = 'd4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              refresh,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic [CNT_W-1:0]  count,
    input logic              timeout,
    input logic              min_err
);
    localparam int NUM_BYTES = CNT_W / BYTE_W;
    localparam logic [ADDR_W-1:0] LOW_ADDR = BASE_ADDR + ADDR_W'(NUM_BYTES - 1);

    p_read_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == LOW_ADDR) |=> reg_rdata == $past(count[BYTE_W-1:0]));

    p_read_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> reg_rdata == '0);

    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && tick_en && count != '0) |=> count == $past(count) - CNT_W'(1));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && !tick_en) |=> $stable(count));

    p_pulse_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    p_pulse_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> count == '0);

    p_stay_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !refresh) |=> count == '0);

    p_min_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> count >= MIN_RELOAD);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        min_err |=> min_err);
endmodule

bind wdt_reload_counter wdt_reload_counter_chk #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W),
    .BASE_ADDR(BASE_ADDR), .MIN_RELOAD(MIN_RELOAD)
) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .refresh(refresh),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .count(count_w), .timeout(timeout), .min_err(min_err)
);

// File: tb/wdt_reload_counter_tb_top.sv
module wdt_reload_counter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en, refresh, reg_wr, reg_rd;
    logic [11:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        timeout, min_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_reload_counter dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .refresh(refresh),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .timeout(timeout), .min_err(min_err)
    );

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    int    vectors = 0;
    int    miscompares = 0;
    logic  rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= reg_rd;

    // Monitor: one read result appears the cycle after each read strobe.
    always @(negedge clk) begin
        item_t it;
        if (rd_seen === 1'b1) begin
            vectors++;
            if (sb_q.size() == 0) begin
                miscompares++;
                $display("FAIL R4: unexpected read data actual=%h expected=none", reg_rdata);
            end else begin
                it = sb_q.pop_front();
                if (reg_rdata !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s: read data actual=%h expected=%h", it.req, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [11:0] a, input logic [7:0] d,
                        input logic rf, input logic tk);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; refresh = rf; tick_en = tk; reg_rd = 1'b0;
    endtask

    task automatic write_b(input logic [11:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic do_refresh();
        step(1'b0, 12'h000, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic read_exp(input logic [11:0] a, input logic [7:0] exp, input string req);
        item_t it;
        @(negedge clk);
        reg_wr = 1'b0; refresh = 1'b0; tick_en = 1'b0; reg_rd = 1'b1; reg_addr = a;
        it.exp = exp; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic read_count(input logic [23:0] exp, input string req);
        read_exp(12'hFF1, exp[23:16], req);
        read_exp(12'hFF2, exp[15:8], req);
        read_exp(12'hFF3, exp[7:0], req);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; refresh = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(32'(timeout), 32'd0, "R1");
        check(32'(min_err), 32'd0, "R1");
        check(32'(reg_rdata), 32'd0, "R1");
        read_count(24'h000400, "R1");
        // R4: unmapped addresses read zero
        read_exp(12'hFF4, 8'h00, "R4");
        read_exp(12'hFF0, 8'h00, "R4");

        // R3: write alone does not touch the count; R2: lane placement
        write_b(12'hFF3, 8'h10);
        read_count(24'h000400, "R3");
        do_refresh();
        read_count(24'h000410, "R2");
        write_b(12'hFF1, 8'h12);
        write_b(12'hFF2, 8'h34);
        write_b(12'hFF3, 8'h56);
        read_count(24'h000410, "R3");
        do_refresh();
        read_count(24'h123456, "R2");

        // R5: five ticks, then idle cycles
        for (int i = 0; i < 5; i++) step(1'b0, 12'h000, 8'h00, 1'b0, 1'b1);
        read_count(24'h123451, "R5");
        for (int i = 0; i < 3; i++) step(1'b0, 12'h000, 8'h00, 1'b0, 1'b0);
        read_count(24'h123451, "R5");

        // R8: write and refresh together load the old reload value
        step(1'b1, 12'hFF3, 8'h99, 1'b1, 1'b0);
        read_count(24'h123456, "R8");
        do_refresh();
        read_count(24'h123499, "R8");

        // R9: refresh beats tick
        step(1'b0, 12'h000, 8'h00, 1'b0, 1'b1);
        step(1'b0, 12'h000, 8'h00, 1'b0, 1'b1);
        step(1'b0, 12'h000, 8'h00, 1'b1, 1'b1);
        read_count(24'h123499, "R9");

        // R6: reload 6, pulse on the sixth tick, then hold at zero
        write_b(12'hFF1, 8'h00);
        write_b(12'hFF2, 8'h00);
        write_b(12'hFF3, 8'h06);
        do_refresh();
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            check(32'(timeout), (i - 1 == 6) ? 32'd1 : 32'd0, "R6");
            if (i == 1) check(32'(min_err), 32'd0, "R7");
            reg_wr = 1'b0; refresh = 1'b0; reg_rd = 1'b0;
            tick_en = (i <= 8);
        end
        read_count(24'h000000, "R6");

        // R7: reload below minimum clamps to 4 and latches the flag
        write_b(12'hFF3, 8'h02);
        do_refresh();
        @(negedge clk);
        refresh = 1'b0;
        check(32'(min_err), 32'd1, "R7");
        read_count(24'h000004, "R7");
        write_b(12'hFF3, 8'h20);
        do_refresh();
        read_count(24'h000020, "R7");
        check(32'(min_err), 32'd1, "R7");
        write_b(12'hFF3, 8'h00);
        do_refresh();
        read_count(24'h000004, "R7");

        repeat (2) @(negedge clk);
        check(32'(sb_q.size()), 32'd0, "R4");
        summary();
        $finish;
    end
endmodule